// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in, first-out buffer, nine bits wide by default, whose write side and read side run on separate clocks. The two clocks may be unrelated, or driven from one source for single-clock use. Pointers cross between the clock domains as gray code. Each side keeps its own view of the fill level and drives its own active-low status flags. The write side drives full and almost-full. The read side drives empty and almost-empty.

Writing needs two enables. Reading needs two enables as well. A mode bit taken from the dual-purpose second write pin while reset is held chooses the meaning of that pin:

- **Dual-enable mode:** the pin is a second write enable.
- **Load mode:** a low level on the pin routes accesses to an external offset register block. FIFO writes and FIFO reads are then held off.

The almost thresholds come in on input ports from that external block. The data output is a registered word behind a tri-state driver that an active-low output enable controls.

Top module: `dcf_fifo`

## Requirements
- R1: In dual-enable mode, a word is stored on a rising write-clock edge only when `wr_en1_ni` is low and `wr_en2_ld_i` is high. Any other combination of these two pins stores nothing.
- R2: A word is moved into the output register on a rising read-clock edge when `rd_en1_ni` and `rd_en2_ni` are both low and the FIFO is not empty. Words leave in the order they were written.
- R3: While `full_no` is low, no word is stored, whatever the enables are. Contents written before that point stay intact.
- R4: While `empty_no` is low, no word is taken, whatever the enables are. The output register keeps the last word read.
- R5: `aempty_no` is low whenever the read side sees `ae_thr_i` or fewer unread words. It is high when it sees `ae_thr_i`+1 or more.
- R6: `afull_no` is low when the write side sees at least DEPTH−`af_thr_i` unread words. It is high when more than `af_thr_i` locations are free.
- R7: `empty_no` is low exactly when no unread word is seen by the read side. `full_no` is low exactly when DEPTH unread words are seen by the write side. Empty and almost-empty change only on read-clock edges. Full and almost-full change only on write-clock edges.
- R8: After reset, the FIFO is empty. `empty_no` and `aempty_no` are low, `full_no` and `afull_no` are high, and the output register holds zero.
- R9: When `oe_ni` is high, `data_o` is high-impedance. When `oe_ni` is low, `data_o` drives the output register.
- R10: The mode is sampled from `wr_en2_ld_i` while `rst_ni` is low. A high level selects dual-enable mode and a low level selects load mode. The mode does not change outside reset. In load mode, a low `wr_en2_ld_i` blocks both FIFO writes and FIFO reads. In dual-enable mode, `wr_en2_ld_i` has no effect on reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low; mode is sampled while low |
| wr_en1_ni | input | 1 | First write enable, active low |
| wr_en2_ld_i | input | 1 | Second write enable (dual-enable mode) or load strobe, low = offset access (load mode) |
| data_i | input | W | Write data |
| rd_en1_ni | input | 1 | First read enable, active low |
| rd_en2_ni | input | 1 | Second read enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| ae_thr_i | input | AW | Almost-empty threshold n |
| af_thr_i | input | AW | Almost-full threshold m |
| data_o | output | W | Output register contents, tri-stated when `oe_ni` is high |
| empty_no | output | 1 | Empty flag, active low, read-clock domain |
| aempty_no | output | 1 | Almost-empty flag, active low, read-clock domain |
| full_no | output | 1 | Full flag, active low, write-clock domain |
| afull_no | output | 1 | Almost-full flag, active low, write-clock domain |

## Verification
A corrupted pointer or a lost gray-code bit shows at the ports within a few cycles, in two ways:

- A flag settles at the wrong fill level once both synchronizers have caught up.
- Words come out of order or duplicated when the buffer is drained.

A write that slips past a full flag ends up overwriting the oldest word. That shows when the full buffer is read back in sequence, and the empty flag then lags the real count. A read that slips past an empty flag changes the held output word on the next read edge. It also leaves the later empty flag low when it should be high.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;

  typedef enum logic {
    MODE_DUAL_WEN = 1'b0,
    MODE_LOAD     = 1'b1
  } dcf_mode_e;

  localparam int unsigned PTR_MAX_W = 16;

  function automatic logic [PTR_MAX_W-1:0] bin2gray(input logic [PTR_MAX_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_MAX_W-1:0] gray2bin(input logic [PTR_MAX_W-1:0] g);
    logic [PTR_MAX_W-1:0] b;
    b[PTR_MAX_W-1] = g[PTR_MAX_W-1];
    for (int i = PTR_MAX_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/dcf_mem.sv
`timescale 1ns/1ps
module dcf_mem #(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en1_ni,
  input  logic          en2_ld_i,
  input  logic [AW-1:0] af_thr_i,
  input  logic [CW-1:0] rgray_sync_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [CW-1:0] wptr_o,
  output logic [CW-1:0] wgray_o,
  output logic          full_no,
  output logic          afull_no
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [CW-1:0] wptr_q, wgray_q, wptr_nxt, rptr_bin, wcnt, af_level;
  logic          full_nq, afull_nq, wr_req, wr_fire;

  // in both modes a FIFO write needs en1 low and the second pin high
  assign wr_req   = !en1_ni && en2_ld_i;
  assign wr_fire  = wr_req && full_nq;
  assign wptr_nxt = wptr_q + CW'(wr_fire);
  assign rptr_bin = CW'(gray2bin(PTR_MAX_W'(rgray_sync_i)));
  assign wcnt     = wptr_nxt - rptr_bin;
  assign af_level = DEPTH_C - {1'b0, af_thr_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q   <= '0;
      wgray_q  <= '0;
      full_nq  <= 1'b1;
      afull_nq <= 1'b1;
    end else begin
      wptr_q   <= wptr_nxt;
      wgray_q  <= CW'(bin2gray(PTR_MAX_W'(wptr_nxt)));
      full_nq  <= (wcnt != DEPTH_C);
      afull_nq <= (wcnt < af_level);
    end
  end

  assign we_o     = wr_fire;
  assign waddr_o  = wptr_q[AW-1:0];
  assign wptr_o   = wptr_q;
  assign wgray_o  = wgray_q;
  assign full_no  = full_nq;
  assign afull_no = afull_nq;
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
module dcf_rd_side
  import dcf_pkg::*;
#(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en1_ni,
  input  logic          en2_ni,
  input  logic          ld_i,
  input  logic [AW-1:0] ae_thr_i,
  input  logic [CW-1:0] wgray_sync_i,
  input  logic [W-1:0]  rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [CW-1:0] rptr_o,
  output logic [CW-1:0] rgray_o,
  output logic [W-1:0]  dout_o,
  output dcf_mode_e     mode_o,
  output logic          empty_no,
  output logic          aempty_no
);
  dcf_mode_e     mode_q;
  logic [CW-1:0] rptr_q, rgray_q, rptr_nxt, wptr_bin, rcnt;
  logic [W-1:0]  dout_q;
  logic          empty_nq, aempty_nq, rd_req, rd_fire;

  // mode captured on read clock while reset is held; clocks run during reset
  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= ld_i ? MODE_DUAL_WEN : MODE_LOAD;
  end

  assign rd_req   = !en1_ni && !en2_ni && ((mode_q == MODE_DUAL_WEN) || ld_i);
  assign rd_fire  = rd_req && empty_nq;
  assign rptr_nxt = rptr_q + CW'(rd_fire);
  assign wptr_bin = CW'(gray2bin(PTR_MAX_W'(wgray_sync_i)));
  assign rcnt     = wptr_bin - rptr_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q    <= '0;
      rgray_q   <= '0;
      dout_q    <= '0;
      empty_nq  <= 1'b0;
      aempty_nq <= 1'b0;
    end else begin
      rptr_q    <= rptr_nxt;
      rgray_q   <= CW'(bin2gray(PTR_MAX_W'(rptr_nxt)));
      if (rd_fire) dout_q <= rdata_i;
      empty_nq  <= (rcnt != '0);
      aempty_nq <= (rcnt > {1'b0, ae_thr_i});
    end
  end

  assign raddr_o   = rptr_q[AW-1:0];
  assign rptr_o    = rptr_q;
  assign rgray_o   = rgray_q;
  assign dout_o    = dout_q;
  assign mode_o    = mode_q;
  assign empty_no  = empty_nq;
  assign aempty_no = aempty_nq;
endmodule

// File: rtl/dcf_fifo.sv
`timescale 1ns/1ps
module dcf_fifo
  import dcf_pkg::*;
#(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wr_en1_ni,
  input  logic          wr_en2_ld_i,
  input  logic [W-1:0]  data_i,
  input  logic          rd_en1_ni,
  input  logic          rd_en2_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] ae_thr_i,
  input  logic [AW-1:0] af_thr_i,
  output logic [W-1:0]  data_o,
  output logic          empty_no,
  output logic          aempty_no,
  output logic          full_no,
  output logic          afull_no
);
  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] wptr_bin, wgray, rptr_bin, rgray, wgray_rs, rgray_ws;
  logic [W-1:0]  rdata, dout_q;
  dcf_mode_e     rd_mode;

  dcf_wr_side #(.DEPTH(DEPTH)) u_wr (
    .clk_i(wclk_i), .rst_ni(rst_ni),
    .en1_ni(wr_en1_ni), .en2_ld_i(wr_en2_ld_i),
    .af_thr_i(af_thr_i), .rgray_sync_i(rgray_ws),
    .we_o(we), .waddr_o(waddr), .wptr_o(wptr_bin), .wgray_o(wgray),
    .full_no(full_no), .afull_no(afull_no)
  );

  dcf_sync #(.W(CW)) u_sync_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray), .q_o(rgray_ws)
  );

  dcf_sync #(.W(CW)) u_sync_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray), .q_o(wgray_rs)
  );

  dcf_mem #(.W(W), .DEPTH(DEPTH)) u_mem (
    .wclk_i(wclk_i), .we_i(we), .waddr_i(waddr), .wdata_i(data_i),
    .raddr_i(raddr), .rdata_o(rdata)
  );

  dcf_rd_side #(.W(W), .DEPTH(DEPTH)) u_rd (
    .clk_i(rclk_i), .rst_ni(rst_ni),
    .en1_ni(rd_en1_ni), .en2_ni(rd_en2_ni), .ld_i(wr_en2_ld_i),
    .ae_thr_i(ae_thr_i), .wgray_sync_i(wgray_rs), .rdata_i(rdata),
    .raddr_o(raddr), .rptr_o(rptr_bin), .rgray_o(rgray), .dout_o(dout_q),
    .mode_o(rd_mode), .empty_no(empty_no), .aempty_no(aempty_no)
  );

  assign data_o = oe_ni ? {W{1'bz}} : dout_q;
endmodule

// File: rtl/dcf_fifo_chk.sv
`timescale 1ns/1ps
module dcf_fifo_chk #(
  parameter int unsigned W  = 9,
  parameter int unsigned CW = 9
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          full_no,
  input logic          afull_no,
  input logic          empty_no,
  input logic          aempty_no,
  input logic [CW-1:0] wptr_i,
  input logic [CW-1:0] rptr_i,
  input logic [W-1:0]  dout_i,
  input logic          mode_i
);
  p_no_overflow_r3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |=> (wptr_i == $past(wptr_i)));

  p_wr_step_r1: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    CW'(wptr_i - $past(wptr_i)) <= CW'(1));

  p_full_afull_r6: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |-> !afull_no);

  p_no_underflow_r4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_no |=> (rptr_i == $past(rptr_i)));

  p_hold_last_r4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_no |=> $stable(dout_i));

  p_empty_aempty_r5: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_no |-> !aempty_no);

  p_mode_static_r10: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rst_ni |=> $stable(mode_i));
endmodule

bind dcf_fifo dcf_fifo_chk #(.W(W), .CW(CW)) u_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni),
  .full_no(full_no), .afull_no(afull_no),
  .empty_no(empty_no), .aempty_no(aempty_no),
  .wptr_i(wptr_bin), .rptr_i(rptr_bin), .dout_i(dout_q),
  .mode_i(rd_mode)
);

// File: tb/dcf_fifo_bench.sv
`timescale 1ns/1ps
module dcf_fifo_bench;
  localparam int W = 9;
  localparam int DEPTH = 256;
  localparam int AW = $clog2(DEPTH);
  localparam int THR = 7;

  logic wclk = 1'b0, rclk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en1_ni = 1'b1, wr_en2_ld_i = 1'b1;
  logic rd_en1_ni = 1'b1, rd_en2_ni = 1'b1, oe_ni = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [AW-1:0] ae_thr_i = AW'(THR), af_thr_i = AW'(THR);
  logic [W-1:0] data_o;
  logic empty_no, aempty_no, full_no, afull_no;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 wclk = ~wclk;   // 100 MHz write clock
  always #7 rclk = ~rclk;   // unrelated read clock

  dcf_fifo #(.W(W), .DEPTH(DEPTH)) u_dcf_fifo (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni),
    .wr_en1_ni(wr_en1_ni), .wr_en2_ld_i(wr_en2_ld_i), .data_i(data_i),
    .rd_en1_ni(rd_en1_ni), .rd_en2_ni(rd_en2_ni), .oe_ni(oe_ni),
    .ae_thr_i(ae_thr_i), .af_thr_i(af_thr_i), .data_o(data_o),
    .empty_no(empty_no), .aempty_no(aempty_no),
    .full_no(full_no), .afull_no(afull_no)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // step off any edge of either clock
  task automatic off_edge();
    #1;
    while (($time % 5) == 0 || ($time % 7) == 0) #1;
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (6) @(negedge wclk);
    off_edge();
  endtask

  task automatic do_reset(input logic pin_level);
    rst_ni = 1'b0;
    wr_en1_ni = 1'b1; rd_en1_ni = 1'b1; rd_en2_ni = 1'b1;
    wr_en2_ld_i = pin_level;
    repeat (5) @(negedge rclk);
    repeat (5) @(negedge wclk);
    off_edge();
    rst_ni = 1'b1;
    repeat (2) @(negedge rclk);
    off_edge();
    wr_en2_ld_i = 1'b1;
    settle();
  endtask

  task automatic wr(input logic [W-1:0] d, input logic en1_n, input logic en2);
    @(negedge wclk); off_edge();
    data_i = d; wr_en1_ni = en1_n; wr_en2_ld_i = en2;
    @(negedge wclk); off_edge();
    wr_en1_ni = 1'b1; wr_en2_ld_i = 1'b1;
  endtask

  task automatic rd(input logic ld);
    @(negedge rclk); off_edge();
    wr_en2_ld_i = ld; rd_en1_ni = 1'b0; rd_en2_ni = 1'b0;
    @(negedge rclk); off_edge();
    rd_en1_ni = 1'b1; rd_en2_ni = 1'b1; wr_en2_ld_i = 1'b1;
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    chk("R8 empty", W'(empty_no), W'(0));
    chk("R8 aempty", W'(aempty_no), W'(0));
    chk("R8 full", W'(full_no), W'(1));
    chk("R8 afull", W'(afull_no), W'(1));
    chk("R8 dout", data_o, W'(0));
  endtask

  task automatic t_order_ae();
    for (int i = 0; i < THR; i++) wr(W'(9'h100 + i), 1'b0, 1'b1);
    settle();
    chk("R7 not empty", W'(empty_no), W'(1));
    chk("R5 n words", W'(aempty_no), W'(0));
    wr(W'(9'h100 + THR), 1'b0, 1'b1);
    settle();
    chk("R5 n+1 words", W'(aempty_no), W'(1));
    for (int i = 0; i <= THR; i++) begin
      rd(1'b1);
      chk("R2 order", data_o, W'(9'h100 + i));
    end
    settle();
    chk("R7 drained", W'(empty_no), W'(0));
    chk("R5 drained", W'(aempty_no), W'(0));
  endtask

  task automatic t_underflow();
    for (int i = 0; i < 3; i++) begin
      rd(1'b1);
      chk("R4 hold", data_o, W'(9'h107));
    end
    wr(W'(9'h055), 1'b0, 1'b1);
    settle();
    rd(1'b1);
    chk("R4 no slip", data_o, W'(9'h055));
    settle();
    chk("R4 empty", W'(empty_no), W'(0));
  endtask

  task automatic t_wen2_gate();
    wr(W'(9'h0F0), 1'b0, 1'b0);
    wr(W'(9'h0F1), 1'b1, 1'b1);
    wr(W'(9'h0F2), 1'b1, 1'b0);
    settle();
    chk("R1 gated", W'(empty_no), W'(0));
    wr(W'(9'h0AA), 1'b0, 1'b1);
    settle();
    chk("R1 stored", W'(empty_no), W'(1));
    rd(1'b0);  // dual mode: second write pin low does not block reads
    chk("R10 dual read", data_o, W'(9'h0AA));
    settle();
    chk("R1 single", W'(empty_no), W'(0));
  endtask

  task automatic t_fill();
    int bad;
    for (int i = 0; i < DEPTH - THR - 1; i++) wr(W'(i), 1'b0, 1'b1);
    settle();
    chk("R6 below", W'(afull_no), W'(1));
    wr(W'(DEPTH - THR - 1), 1'b0, 1'b1);
    settle();
    chk("R6 at DEPTH-m", W'(afull_no), W'(0));
    chk("R7 not full", W'(full_no), W'(1));
    for (int i = DEPTH - THR; i < DEPTH; i++) wr(W'(i), 1'b0, 1'b1);
    settle();
    chk("R7 full", W'(full_no), W'(0));
    for (int i = 0; i < 3; i++) wr(W'(9'h1FF), 1'b0, 1'b1);
    settle();
    chk("R3 still full", W'(full_no), W'(0));
    bad = 0;
    for (int i = 0; i < DEPTH; i++) begin
      rd(1'b1);
      if (data_o !== W'(i)) begin
        bad++;
        if (bad < 4) chk("R3 content", data_o, W'(i));
      end
    end
    n_checks++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL R3 content: actual %0d mismatches expected 0", bad);
    end
    settle();
    chk("R3 empty after drain", W'(empty_no), W'(0));
    chk("R6 released", W'(afull_no), W'(1));
  endtask

  task automatic t_oe();
    @(negedge wclk); off_edge();
    oe_ni = 1'b1;
    #1;
    chk("R9 high-z", data_o, {W{1'bz}});
    oe_ni = 1'b0;
    #1;
    chk("R9 drive", data_o, W'(DEPTH - 1));
  endtask

  task automatic t_load_mode();
    do_reset(1'b0);
    chk("R8 load reset", W'(empty_no), W'(0));
    wr(W'(9'h033), 1'b0, 1'b1);
    wr(W'(9'h044), 1'b0, 1'b0);  // offset access, not a FIFO write
    settle();
    chk("R10 one word", W'(empty_no), W'(1));
    rd(1'b0);
    chk("R10 ld blocks read", data_o, W'(0));
    rd(1'b1);
    chk("R10 read", data_o, W'(9'h033));
    settle();
    chk("R10 ld blocks write", W'(empty_no), W'(0));
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  initial begin
    t_reset();
    t_order_ae();
    t_underflow();
    t_wen2_gate();
    t_fill();
    t_oe();
    t_load_mode();
    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule